// File: doc/BRIEF.md
# Dual-Channel Tri-State Phase Detector with Lock Detection

This block sits between the divider outputs of two synthesizer loops and their charge pumps. For each channel it takes a single-cycle reference strobe and a single-cycle feedback strobe, both synchronous to the oscillator clock. It drives a three-state pump command: drive high, drive low, or release. A polarity bit per channel sets which direction means "speed up", to suit the slope of the external oscillator and filter. The detector is a three-state machine that remembers which strobe came first. Any timing difference from minus one full comparison period to plus one full period yields a correction of the right sign. An offset of one clock cycle yields a pulse of one clock cycle, so small errors are never swallowed.

Each channel times its correction pulse in oscillator cycles, and the count saturates at 15. A lock flag falls as soon as a pulse reaches the unlock threshold. It rises again only after three comparison periods in a row whose pulse stayed small. A power-save input per channel releases the pump, clears the detector and the lock flag, and arms a limiter. The limiter keeps the first correction after wake-up to at most two cycles, so the oscillator does not jump.

One shared status pin shows either the combined lock state of both channels or one of the four raw strobe streams, chosen by a 3-bit select.

Top module: `pd_top`

## Requirements
- R1: While a channel drives (cp_oe=1), cp_hi is 1 when the reference led and polarity is 1, or when the feedback led and polarity is 0. Otherwise cp_hi is 0.
- R2: A reference strobe that leads the feedback strobe by N cycles gives exactly N consecutive driving cycles, and a feedback lead of N cycles does the same. Strobes in the same cycle give no drive. A lead of one cycle gives a one-cycle pulse.
- R3: A second reference strobe while the detector is already correcting upward keeps it in that state, with no release. The pulse lasts until the next feedback strobe, and the same holds symmetrically for the downward direction.
- R4: While psave of a channel is 1, its cp_oe is 0 in the same cycle. Power save also clears that channel's detector state and lock flag.
- R5: In the first comparison period after power save is released, the pulse is cut off after CLAMP_W (default 2) driving cycles. Later periods are not limited.
- R6: A channel's lock flag clears in the cycle in which its running pulse length reaches UNLOCK_TH (default 2) cycles. The pulse-length count saturates at CNT_MAX (default 15).
- R7: A comparison period counts as good when its pulse length is below UNLOCK_TH and at most LOCK_TH. The lock flag sets at the close of the LOCK_RUN-th (default 3) consecutive good period.
- R8: The combined lock state is 1 only when every channel is locked or in power save.
- R9: With the select sel = {lds,t1,t2}, any code with sel[2]=0 (000, 001, 010, 011) puts the combined lock state on stat_pin. Code 100 shows fr[0], 110 shows fr[1], 101 shows fp[0] and 111 shows fp[1].
- R10: After reset, no channel drives, every detector is idle and every lock flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| fr | input | 2 | Reference strobe per channel, one cycle wide |
| fp | input | 2 | Feedback strobe per channel, one cycle wide |
| pol | input | 2 | Output polarity per channel |
| psave | input | 2 | Power save per channel, active high |
| sel | input | 3 | Status pin select {lds,t1,t2} |
| cp_oe | output | 2 | Pump drive enable per channel (0 = high impedance) |
| cp_hi | output | 2 | Pump drive level per channel |
| stat_pin | output | 1 | Shared status output |

## Verification
Some properties are checked on every cycle:
- a channel in power save never drives;
- a lock flag only rises at the close of a comparison period;
- a running pulse past the unlock threshold always clears the flag;
- the wake-up limiter cuts the drive;
- the shared pin follows the combined lock state whenever a lock code is selected.

Other behaviour can only be shown by the bench's scenarios:
- pulse widths and levels for given lead/lag patterns and both polarities;
- the three-period run needed to lock;
- the width of the first correction after wake-up;
- the four strobe codes on the status pin.

// File: rtl/pd_pkg.sv
package pd_pkg;
    localparam int NCH        = 2;
    localparam int CNT_W      = 4;
    localparam int CNT_MAX    = 15;
    localparam int UNLOCK_TH  = 2;
    localparam int LOCK_TH    = 4;
    localparam int LOCK_RUN   = 3;
    localparam int CLAMP_W    = 2;

    typedef enum logic [1:0] {
        PD_IDLE = 2'd0,
        PD_UP   = 2'd1,
        PD_DN   = 2'd2
    } pd_state_e;

    typedef struct packed {
        logic drive;
        logic level;
    } cp_cmd_t;

    function automatic pd_state_e pd_next(input pd_state_e cur, input logic r, input logic f);
        pd_state_e nxt;
        nxt = cur;
        case (cur)
            PD_IDLE: if (r && !f) nxt = PD_UP;
                     else if (f && !r) nxt = PD_DN;
            PD_UP:   if (f && !r) nxt = PD_IDLE;
            PD_DN:   if (r && !f) nxt = PD_IDLE;
            default: nxt = PD_IDLE;
        endcase
        return nxt;
    endfunction
endpackage

// File: rtl/pd_core.sv
module pd_core
    import pd_pkg::*;
#(
    parameter int CW    = CNT_W,
    parameter int CLMP  = CLAMP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fr,
    input  logic          fp,
    input  logic          pol,
    input  logic          psave,
    input  logic [CW-1:0] cnt,
    output cp_cmd_t       cmd,
    output logic          act,
    output logic          close_evt,
    output logic          first_cmp
);
    localparam logic [CW-1:0] CLAMP_V = CW'(CLMP);

    pd_state_e st_q, st_d;
    logic      first_q;
    logic      clamp;

    always_comb begin
        st_d      = pd_next(st_q, fr, fp);
        close_evt = !psave && (((st_q != PD_IDLE) && (st_d == PD_IDLE)) ||
                               ((st_q == PD_IDLE) && fr && fp));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= PD_IDLE;
            first_q <= 1'b0;
        end else if (psave) begin
            st_q    <= PD_IDLE;
            first_q <= 1'b1;
        end else begin
            st_q <= st_d;
            if (close_evt) first_q <= 1'b0;
        end
    end

    assign act       = (st_q != PD_IDLE);
    assign first_cmp = first_q;
    assign clamp     = first_q && (cnt >= CLAMP_V);

    always_comb begin
        cmd.drive = act && !psave && !clamp;
        cmd.level = ((st_q == PD_UP) == pol);
    end
endmodule

// File: rtl/pd_lock.sv
module pd_lock
    import pd_pkg::*;
#(
    parameter int CW   = CNT_W,
    parameter int CMAX = CNT_MAX,
    parameter int UTH  = UNLOCK_TH,
    parameter int LTH  = LOCK_TH,
    parameter int RUN  = LOCK_RUN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          psave,
    input  logic          act,
    input  logic          close_evt,
    output logic [CW-1:0] cnt,
    output logic          locked
);
    localparam int RW = $clog2(RUN + 1);
    localparam logic [CW-1:0] CMAX_V = CW'(CMAX);
    localparam logic [CW-1:0] UTH_V  = CW'(UTH);
    localparam logic [CW-1:0] LTH_V  = CW'(LTH);
    localparam logic [RW-1:0] RUN_V  = RW'(RUN);

    logic [CW-1:0] cnt_q, cnt_inc, err;
    logic [RW-1:0] run_q;
    logic          lock_q, bad, good;

    always_comb begin
        cnt_inc = (cnt_q == CMAX_V) ? cnt_q : cnt_q + 1'b1;
        err     = act ? cnt_inc : '0;
        bad     = act && (cnt_inc >= UTH_V);
        good    = close_evt && (err < UTH_V) && (err <= LTH_V);
    end

    always_ff @(posedge clk) begin
        if (rst || psave) begin
            cnt_q  <= '0;
            run_q  <= '0;
            lock_q <= 1'b0;
        end else begin
            cnt_q <= (act && !close_evt) ? cnt_inc : '0;
            if (bad) begin
                lock_q <= 1'b0;
                run_q  <= '0;
            end else if (good) begin
                if (run_q != RUN_V) run_q <= run_q + 1'b1;
                if (run_q + 1'b1 >= RUN_V) lock_q <= 1'b1;
            end
        end
    end

    assign cnt    = cnt_q;
    assign locked = lock_q;
endmodule

// File: rtl/pd_status_mux.sv
module pd_status_mux
    import pd_pkg::*;
(
    input  logic [2:0]     sel,
    input  logic [NCH-1:0] lock_v,
    input  logic [NCH-1:0] psave,
    input  logic [NCH-1:0] fr,
    input  logic [NCH-1:0] fp,
    output logic           stat
);
    logic lock_all;

    always_comb begin
        lock_all = &(lock_v | psave);
        if (!sel[2])     stat = lock_all;
        else if (sel[0]) stat = fp[sel[1]];
        else             stat = fr[sel[1]];
    end
endmodule

// File: rtl/pd_top.sv
module pd_top
    import pd_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] fr,
    input  logic [NCH-1:0] fp,
    input  logic [NCH-1:0] pol,
    input  logic [NCH-1:0] psave,
    input  logic [2:0]     sel,
    output logic [NCH-1:0] cp_oe,
    output logic [NCH-1:0] cp_hi,
    output logic           stat_pin
);
    logic [NCH-1:0]            act_v;
    logic [NCH-1:0]            close_v;
    logic [NCH-1:0]            lock_v;
    logic [NCH-1:0]            first_v;
    logic [NCH-1:0][CNT_W-1:0] cnt_v;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        cp_cmd_t cmd;

        pd_core #(.CW(CNT_W), .CLMP(CLAMP_W)) u_core (
            .clk       (clk),
            .rst       (rst),
            .fr        (fr[g]),
            .fp        (fp[g]),
            .pol       (pol[g]),
            .psave     (psave[g]),
            .cnt       (cnt_v[g]),
            .cmd       (cmd),
            .act       (act_v[g]),
            .close_evt (close_v[g]),
            .first_cmp (first_v[g])
        );

        pd_lock #(.CW(CNT_W), .CMAX(CNT_MAX), .UTH(UNLOCK_TH),
                  .LTH(LOCK_TH), .RUN(LOCK_RUN)) u_lock (
            .clk       (clk),
            .rst       (rst),
            .psave     (psave[g]),
            .act       (act_v[g]),
            .close_evt (close_v[g]),
            .cnt       (cnt_v[g]),
            .locked    (lock_v[g])
        );

        assign cp_oe[g] = cmd.drive;
        assign cp_hi[g] = cmd.level;
    end

    pd_status_mux u_mux (
        .sel    (sel),
        .lock_v (lock_v),
        .psave  (psave),
        .fr     (fr),
        .fp     (fp),
        .stat   (stat_pin)
    );
endmodule

// File: rtl/pd_top_chk.sv
module pd_top_chk
    import pd_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic [NCH-1:0]            psave,
    input logic [2:0]                sel,
    input logic [NCH-1:0]            cp_oe,
    input logic                      stat_pin,
    input logic [NCH-1:0]            act_v,
    input logic [NCH-1:0]            close_v,
    input logic [NCH-1:0]            lock_v,
    input logic [NCH-1:0]            first_v,
    input logic [NCH-1:0][CNT_W-1:0] cnt_v
);
    for (genvar i = 0; i < NCH; i++) begin : g_chk
        a_r4_psave_hiz: assert property (@(posedge clk) disable iff (rst)
            psave[i] |-> !cp_oe[i]);

        a_r5_wake_clamp: assert property (@(posedge clk) disable iff (rst)
            (first_v[i] && (cnt_v[i] >= CNT_W'(CLAMP_W))) |-> !cp_oe[i]);

        a_r6_unlock_fall: assert property (@(posedge clk) disable iff (rst)
            (act_v[i] && !psave[i] && (cnt_v[i] >= CNT_W'(UNLOCK_TH - 1))) |=> !lock_v[i]);

        a_r7_lock_at_close: assert property (@(posedge clk) disable iff (rst)
            $rose(lock_v[i]) |-> $past(close_v[i]));
    end

    a_r8_pin_shows_lock: assert property (@(posedge clk) disable iff (rst)
        !sel[2] |-> (stat_pin == &(lock_v | psave)));
endmodule

bind pd_top pd_top_chk u_chk (.*);

// File: tb/tb_pd_top.sv
`timescale 1ns/1ps
module tb_pd_top;
    import pd_pkg::*;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] fr = '0, fp = '0, pol = '0, psave = '0;
    logic [2:0]     sel = 3'b000;
    logic [NCH-1:0] cp_oe, cp_hi;
    logic           stat_pin;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pd_top dut (.clk(clk), .rst(rst), .fr(fr), .fp(fp), .pol(pol), .psave(psave),
                .sel(sel), .cp_oe(cp_oe), .cp_hi(cp_hi), .stat_pin(stat_pin));

    // {pol, fr mask, fp mask, expected width, expected all-high}
    localparam logic [38:0] VEC [8] = '{
        {1'b1, 16'h0001, 16'h0002, 5'd1, 1'b1},
        {1'b1, 16'h0002, 16'h0001, 5'd1, 1'b0},
        {1'b1, 16'h0001, 16'h0008, 5'd3, 1'b1},
        {1'b0, 16'h0001, 16'h0004, 5'd2, 1'b0},
        {1'b0, 16'h0010, 16'h0001, 5'd4, 1'b1},
        {1'b1, 16'h0001, 16'h0001, 5'd0, 1'b0},
        {1'b1, 16'h0005, 16'h0010, 5'd4, 1'b1},
        {1'b1, 16'h0040, 16'h0005, 5'd6, 1'b0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic run_seq(input int ch, input logic [15:0] frm, input logic [15:0] fpm,
                           output int w, output int h);
        w = 0;
        h = 0;
        for (int j = 0; j < 16; j++) begin
            step();
            if (cp_oe[ch]) begin
                w++;
                if (cp_hi[ch]) h++;
            end
            fr = '0;
            fp = '0;
            fr[ch] = frm[j];
            fp[ch] = fpm[j];
        end
        fr = '0;
        fp = '0;
    endtask

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int w, h;
        psave = 2'b10;
        pol   = 2'b11;
        repeat (3) step();
        rst = 1'b0;
        step();
        // R10 reset state
        check(cp_oe == 2'b00, "R10 no drive", cp_oe, 0);
        check(stat_pin == 1'b0, "R10 lock clear", stat_pin, 0);

        // R1 R2 R3 table of lead/lag patterns on channel 0
        for (int v = 0; v < 8; v++) begin
            int ew, eh;
            pol[0] = VEC[v][38];
            ew = int'(VEC[v][5:1]);
            eh = VEC[v][0] ? ew : 0;
            run_seq(0, VEC[v][37:22], VEC[v][21:6], w, h);
            check(w == ew, "R2 R3 width", w, ew);
            check(h == eh, "R1 level", h, eh);
        end

        // R4 power save releases pump at once
        pol[0] = 1'b1;
        fr[0] = 1'b1;
        step();
        fr[0] = 1'b0;
        step();
        check(cp_oe[0] == 1'b1, "R4 driving before save", cp_oe[0], 1);
        psave[0] = 1'b1;
        #1;
        check(cp_oe[0] == 1'b0, "R4 hiz in save", cp_oe[0], 0);
        repeat (3) step();
        psave[0] = 1'b0;
        // R5 first correction after wake clamped
        run_seq(0, 16'h0001, 16'h0020, w, h);
        check(w == CLAMP_W, "R5 clamped width", w, CLAMP_W);
        run_seq(0, 16'h0001, 16'h0020, w, h);
        check(w == 5, "R5 later unclamped", w, 5);

        // R7 lock after three good periods
        run_seq(0, 16'h0001, 16'h0002, w, h);
        check(stat_pin == 1'b0, "R7 one good", stat_pin, 0);
        run_seq(0, 16'h0002, 16'h0001, w, h);
        check(stat_pin == 1'b0, "R7 two good", stat_pin, 0);
        run_seq(0, 16'h0001, 16'h0002, w, h);
        check(stat_pin == 1'b1, "R7 three good", stat_pin, 1);
        // R6 error of two cycles unlocks
        run_seq(0, 16'h0001, 16'h0004, w, h);
        check(stat_pin == 1'b0, "R6 unlock at two", stat_pin, 0);
        // R6 long pulse keeps driving past saturation then unlock stays
        run_seq(0, 16'h0001, 16'h0000, w, h);
        check(w == 15 && cp_oe[0], "R6 long pulse", w, 15);
        run_seq(0, 16'h0000, 16'h0010, w, h);
        check(stat_pin == 1'b0, "R6 still unlocked", stat_pin, 0);

        // relock, then R8 combination
        for (int k = 0; k < 3; k++) run_seq(0, 16'h0001, 16'h0002, w, h);
        check(stat_pin == 1'b1, "R8 locked plus save", stat_pin, 1);
        psave[1] = 1'b0;
        #1;
        check(stat_pin == 1'b0, "R8 other unlocked", stat_pin, 0);
        psave[1] = 1'b1;
        #1;
        check(stat_pin == 1'b1, "R8 other saved", stat_pin, 1);
        psave[0] = 1'b1;
        step();
        check(stat_pin == 1'b1, "R8 both saved", stat_pin, 1);
        psave[0] = 1'b0;
        #1;
        check(stat_pin == 1'b0, "R4 lock cleared by save", stat_pin, 0);

        // R9 status pin decode
        sel = 3'b011;
        #1;
        check(stat_pin == 1'b0, "R9 code 011 lock", stat_pin, 0);
        sel = 3'b110;
        fr[1] = 1'b1;
        #1;
        check(stat_pin == 1'b1, "R9 code 110 fr1", stat_pin, 1);
        sel = 3'b111;
        #1;
        check(stat_pin == 1'b0, "R9 code 111 fp1 low", stat_pin, 0);
        fp[1] = 1'b1;
        fr[1] = 1'b0;
        #1;
        check(stat_pin == 1'b1, "R9 code 111 fp1", stat_pin, 1);
        sel = 3'b101;
        #1;
        check(stat_pin == 1'b0, "R9 code 101 fp0", stat_pin, 0);
        sel = 3'b100;
        fp[1] = 1'b0;
        fr[0] = 1'b1;
        #1;
        check(stat_pin == 1'b1, "R9 code 100 fr0", stat_pin, 1);
        sel = 3'b000;
        #1;
        check(stat_pin == 1'b0, "R9 code 000 lock", stat_pin, 0);
        step();
        fr[0] = 1'b0;
        fp[0] = 1'b1;
        step();
        fp[0] = 1'b0;
        step();

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule